// File: doc/BRIEF.md
# Time-of-Day Counter with Wildcard Alarm

This block keeps a seconds, minutes and hours count. Each field is stored either as packed BCD or as plain binary, and the hours run in either a 24-hour or a 12-hour format. An internal phase divider counts a 32 kHz tick input. Each time the divider completes one second, the time advances and an update-done flag is raised.

After each advance, the new time is compared against three alarm bytes. Any alarm byte can be made a wildcard. When all three fields match, an alarm flag is raised.

Software has the following controls:
- A hold bit freezes the time so that it can be written safely.
- A divider-reset control parks the divider.
- A status output warns that an advance is about to happen.
- Two enables combine the flags into one interrupt line.
- A flag-clear strobe acknowledges both flags.

Top module: `rtc_tod_core`

## Requirements
- R1: With `bin_mode`=0 every field is packed BCD (tens digit in bits 7:4, ones digit in bits 3:0), and a ones digit of 9 carries into the tens digit in the same update. With `bin_mode`=1 every field is plain binary.
- R2: Seconds and minutes roll from 59 to 0 and carry into the next field. In 24-hour mode (`hour24_mode`=1) the hours roll from 23 to 0.
- R3: In 12-hour mode the hour byte holds 1..12 in bits 6:0, and bit 7 set means PM. 11 advances to 12 and toggles bit 7; 12 advances to 1 and keeps bit 7. For alarm comparison, 12 AM counts as hour 0 and 12 PM counts as hour 12.
- R4: An alarm byte with bits 7:6 both 1 matches any value of its field.
- R5: Every one-second update sets `update_flag_o`. An update whose new time matches all three alarm fields sets `alarm_flag_o`. `flag_clr` clears both flags, but a set in the same cycle wins.
- R6: While `set_hold`=1 the time does not advance and no alarm is raised. `update_flag_o` is still set, but its interrupt enable acts as 0.
- R7: `uip_o` is 1 during the last UIP_TICKS ticks of each second (divider phase >= TICKS_PER_SEC-UIP_TICKS). It is 0 while `set_hold` or `div_reset` is 1.
- R8: While `div_reset`=1 no update happens. After release, the first update comes TICKS_PER_SEC/2 ticks later.
- R9: `irq_o` = (`update_flag_o` & `upd_irq_en` & !`set_hold`) | (`alarm_flag_o` & `alm_irq_en`).
- R10: After reset the time, alarms, flags, `uip_o` and `irq_o` are all 0, and the divider phase is 0.
- R11: A write with `wr_en`=1 stores `wr_data` into the field chosen by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 alarm seconds, 4 alarm minutes, 5 alarm hours. An alarm write leaves the time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz tick |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD |
| hour24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| set_hold | input | 1 | Freeze the time for writing |
| div_reset | input | 1 | Park the divider at half a second |
| upd_irq_en | input | 1 | Update-done interrupt enable |
| alm_irq_en | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | Clear both flags |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Field select for writes |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field |
| update_flag_o | output | 1 | Update-done flag |
| alarm_flag_o | output | 1 | Alarm flag |
| uip_o | output | 1 | Update-in-progress status |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions assume the following about the inputs:
- A time write never lands in the same cycle as a one-second update.
- The mode bits stay steady across the update that uses them.
- Fields hold legal values for the selected encoding.

The bench keeps within these limits. It changes modes and writes fields only while `tick_32k` is low, so the divider cannot complete a second during a write. It also writes only legal BCD or binary values that match the mode it has just set.

// File: rtl/rtc_tod_pkg.sv
package rtc_tod_pkg;

  localparam logic [2:0] SEL_SEC   = 3'd0;
  localparam logic [2:0] SEL_MIN   = 3'd1;
  localparam logic [2:0] SEL_HOUR  = 3'd2;
  localparam logic [2:0] SEL_ASEC  = 3'd3;
  localparam int         N_ALARM   = 3;
  localparam logic [1:0] WILDCARD  = 2'b11;

  // encode a small number in the current field format
  function automatic logic [7:0] enc_val(input logic [6:0] n, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = n / 7'd10;
    ones = n % 7'd10;
    enc_val = bin ? {1'b0, n} : {tens[3:0], ones[3:0]};
  endfunction

  // add one; BCD carries 9 into the tens digit, other digits pass through
  function automatic logic [7:0] step_digit(input logic [7:0] v, input logic bin);
    if (bin)                 step_digit = v + 8'd1;
    else if (v[3:0] == 4'd9) step_digit = {v[7:4] + 4'd1, 4'd0};
    else                     step_digit = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // {wrapped, next} for a field whose last value is top
  function automatic logic [8:0] step_field(input logic [7:0] v, input logic [6:0] top,
                                            input logic bin);
    if (v == enc_val(top, bin)) step_field = {1'b1, 8'd0};
    else                        step_field = {1'b0, step_digit(v, bin)};
  endfunction

  function automatic logic [7:0] to_bin(input logic [7:0] v, input logic bin);
    logic [7:0] t;
    t = {4'd0, v[7:4]};
    to_bin = bin ? v : (t * 8'd10 + {4'd0, v[3:0]});
  endfunction

  // hour as 0..23 regardless of format
  function automatic logic [7:0] hour_norm(input logic [7:0] v, input logic bin,
                                           input logic h24);
    logic [7:0] h;
    if (h24) begin
      hour_norm = to_bin(v, bin);
    end else begin
      h = to_bin({1'b0, v[6:0]}, bin) % 8'd12;
      hour_norm = h + (v[7] ? 8'd12 : 8'd0);
    end
  endfunction

endpackage

// File: rtl/rtc_tod_divider.sv
module rtc_tod_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic div_reset,
  input  logic hold,
  output logic second_evt,
  output logic uip
);
  localparam int            CW        = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF      = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] UIP_START = CW'(TICKS_PER_SEC - UIP_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = div_reset | tick;
    if (div_reset)          cnt_d = HALF;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign second_evt = tick & ~div_reset & (cnt_q == LAST);
  assign uip        = ~div_reset & ~hold & (cnt_q >= UIP_START);

  // R8: a parked divider sits half a second from its next update
  assert_parked_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_reset |=> cnt_q == HALF);

  // R8: a completed second restarts the phase
  assert_phase_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    second_evt |=> cnt_q == '0);

endmodule

// File: rtl/rtc_tod_time.sv
module rtc_tod_time
  import rtc_tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bin,
  input  logic       h24,
  input  logic       adv,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] nxt_sec,
  output logic [7:0] nxt_min,
  output logic [7:0] nxt_hour
);
  logic [8:0] s_step, m_step, h_step;
  logic [7:0] h7, e11, e12, hinc, nh;
  logic [7:0] sec_d, min_d, hour_d;
  logic       sec_en, min_en, hour_en;
  logic       wr_s, wr_m, wr_h;

  always_comb begin
    s_step = step_field(sec_q, 7'd59, bin);
    m_step = step_field(min_q, 7'd59, bin);
    h_step = step_field(hour_q, 7'd23, bin);
    h7     = {1'b0, hour_q[6:0]};
    e11    = enc_val(7'd11, bin);
    e12    = enc_val(7'd12, bin);
    hinc   = step_digit(h7, bin);
    if (h24)             nh = h_step[8] ? 8'h00 : h_step[7:0];
    else if (h7 == e12)  nh = {hour_q[7], 7'd1};
    else if (h7 == e11)  nh = {~hour_q[7], 7'd0} | (e12 & 8'h7F);
    else                 nh = {hour_q[7], 7'd0} | (hinc & 8'h7F);
    nxt_sec  = s_step[7:0];
    nxt_min  = s_step[8] ? m_step[7:0] : min_q;
    nxt_hour = (s_step[8] & m_step[8]) ? nh : hour_q;
  end

  always_comb begin
    wr_s    = wr_en & (wr_sel == SEL_SEC);
    wr_m    = wr_en & (wr_sel == SEL_MIN);
    wr_h    = wr_en & (wr_sel == SEL_HOUR);
    sec_en  = wr_s | adv;
    min_en  = wr_m | adv;
    hour_en = wr_h | adv;
    sec_d   = wr_s ? wr_data : nxt_sec;
    min_d   = wr_m ? wr_data : nxt_min;
    hour_d  = wr_h ? wr_data : nxt_hour;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else begin
      if (sec_en)  sec_q  <= sec_d;
      if (min_en)  min_q  <= min_d;
      if (hour_en) hour_q <= hour_d;
    end
  end

  // R2: seconds roll over at 59
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && sec_q == enc_val(7'd59, bin)) |=> sec_q == 8'h00);

  // R2: 23:59:59 in 24-hour mode rolls to hour 0
  assert_day_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && h24 && sec_q == enc_val(7'd59, bin) &&
     min_q == enc_val(7'd59, bin) && hour_q == enc_val(7'd23, bin)) |=> hour_q == 8'h00);

endmodule

// File: rtl/rtc_tod_alarm.sv
module rtc_tod_alarm
  import rtc_tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bin,
  input  logic       h24,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  output logic       match
);
  logic [7:0] alm_q [N_ALARM];
  logic       m_sec, m_min, m_hour;

  for (genvar i = 0; i < N_ALARM; i++) begin : g_alm
    logic hit;
    assign hit = wr_en & (wr_sel == SEL_ASEC + 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   alm_q[i] <= '0;
      else if (hit) alm_q[i] <= wr_data;
    end
  end

  always_comb begin
    m_sec  = (alm_q[0][7:6] == WILDCARD) || (alm_q[0] == cur_sec);
    m_min  = (alm_q[1][7:6] == WILDCARD) || (alm_q[1] == cur_min);
    m_hour = (alm_q[2][7:6] == WILDCARD) ||
             (hour_norm(alm_q[2], bin, h24) == hour_norm(cur_hour, bin, h24));
    match  = m_sec & m_min & m_hour;
  end

endmodule

// File: rtl/rtc_tod_core.sv
module rtc_tod_core #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       bin_mode,
  input  logic       hour24_mode,
  input  logic       set_hold,
  input  logic       div_reset,
  input  logic       upd_irq_en,
  input  logic       alm_irq_en,
  input  logic       flag_clr,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       update_flag_o,
  output logic       alarm_flag_o,
  output logic       uip_o,
  output logic       irq_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       sec_evt, adv, alm_match;
  logic [7:0] nxt_sec, nxt_min, nxt_hour;
  logic       uf_q, uf_d, af_q, af_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  rtc_tod_divider #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick_32k), .div_reset(div_reset),
    .hold(set_hold), .second_evt(sec_evt), .uip(uip_o));

  assign adv = sec_evt & ~set_hold;

  rtc_tod_time u_time (
    .clk(clk), .rst_n(rst_sync_n), .bin(bin_mode), .h24(hour24_mode), .adv(adv),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_q(sec_o), .min_q(min_o), .hour_q(hour_o),
    .nxt_sec(nxt_sec), .nxt_min(nxt_min), .nxt_hour(nxt_hour));

  rtc_tod_alarm u_alarm (
    .clk(clk), .rst_n(rst_sync_n), .bin(bin_mode), .h24(hour24_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_sec(nxt_sec), .cur_min(nxt_min), .cur_hour(nxt_hour), .match(alm_match));

  always_comb begin
    if (sec_evt)       uf_d = 1'b1;
    else if (flag_clr) uf_d = 1'b0;
    else               uf_d = uf_q;
    if (adv && alm_match) af_d = 1'b1;
    else if (flag_clr)    af_d = 1'b0;
    else                  af_d = af_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      uf_q <= 1'b0;
      af_q <= 1'b0;
    end else begin
      uf_q <= uf_d;
      af_q <= af_d;
    end
  end

  assign update_flag_o = uf_q;
  assign alarm_flag_o  = af_q;
  assign irq_o = (uf_q & upd_irq_en & ~set_hold) | (af_q & alm_irq_en);

  // R7: status warns ahead of every running update
  assert_uip_ahead_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_evt && !set_hold) |-> uip_o);

  // R6: a held time only changes through writes
  assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_hold && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)));

  // R5: alarm flag only rises from an advancing update
  assert_alarm_source_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(alarm_flag_o) |-> $past(sec_evt && !set_hold));

  // R5: clear without update empties the update flag
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_clr && !sec_evt) |=> !update_flag_o);

  // R9: under hold only the alarm path may drive the interrupt
  assert_irq_hold_mask_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_hold && irq_o) |-> (alarm_flag_o && alm_irq_en));

endmodule

// File: tb/test_rtc_tod_core.sv
module test_rtc_tod_core;
  localparam int TPS = 64;
  localparam int UIPT = 8;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n, tick, bin_mode, hour24_mode, set_hold, div_reset;
  logic upd_irq_en, alm_irq_en, flag_clr, wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] sec_o, min_o, hour_o;
  logic update_flag_o, alarm_flag_o, uip_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rtc_tod_core #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) i_rtc_tod_core (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .bin_mode(bin_mode),
    .hour24_mode(hour24_mode), .set_hold(set_hold), .div_reset(div_reset),
    .upd_irq_en(upd_irq_en), .alm_irq_en(alm_irq_en), .flag_clr(flag_clr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .update_flag_o(update_flag_o), .alarm_flag_o(alarm_flag_o),
    .uip_o(uip_o), .irq_o(irq_o));

  // {bin, h24, h, m, s, alarm h, alarm m, alarm s, exp h, exp m, exp s, exp alarm}
  localparam logic [74:0] VEC [NV] = '{
    {1'b0,1'b1, 8'h00,8'h00,8'h00, 8'hC0,8'hC0,8'hC0, 8'h00,8'h00,8'h01, 1'b1}, // R4 all wild
    {1'b0,1'b1, 8'h12,8'h34,8'h59, 8'h12,8'h35,8'h00, 8'h12,8'h35,8'h00, 1'b1}, // R1 R5
    {1'b0,1'b1, 8'h23,8'h59,8'h59, 8'h01,8'h00,8'h00, 8'h00,8'h00,8'h00, 1'b0}, // R2
    {1'b0,1'b1, 8'h09,8'h09,8'h09, 8'hC0,8'h10,8'hC0, 8'h09,8'h09,8'h10, 1'b0}, // R1 R4
    {1'b1,1'b1, 8'h17,8'h3B,8'h3B, 8'h00,8'h00,8'h00, 8'h00,8'h00,8'h00, 1'b1}, // R1 R2
    {1'b1,1'b1, 8'h05,8'h09,8'h09, 8'hFF,8'hFF,8'h0A, 8'h05,8'h09,8'h0A, 1'b1}, // R1 R4
    {1'b0,1'b0, 8'h11,8'h59,8'h59, 8'h92,8'h00,8'h00, 8'h92,8'h00,8'h00, 1'b1}, // R3 AM->PM
    {1'b0,1'b0, 8'h92,8'h59,8'h59, 8'h81,8'h00,8'h00, 8'h81,8'h00,8'h00, 1'b1}, // R3 12->1
    {1'b0,1'b0, 8'h91,8'h59,8'h59, 8'h12,8'h00,8'h00, 8'h12,8'h00,8'h00, 1'b1}, // R3 PM->AM
    {1'b1,1'b0, 8'h0C,8'h00,8'h05, 8'h8C,8'h00,8'h06, 8'h0C,8'h00,8'h06, 1'b0}, // R3 12AM vs 12PM
    {1'b0,1'b1, 8'h00,8'h00,8'h30, 8'h00,8'h00,8'h30, 8'h00,8'h00,8'h31, 1'b0}  // R5 past match
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr;
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [74:0] v;

  initial begin
    rst_n = 1'b0; tick = 1'b0; bin_mode = 1'b0; hour24_mode = 1'b1;
    set_hold = 1'b0; div_reset = 1'b0; upd_irq_en = 1'b0; alm_irq_en = 1'b0;
    flag_clr = 1'b0; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk("R10 time", {8'd0, hour_o, min_o, sec_o}, 32'd0);
    chk("R10 flags", {28'd0, update_flag_o, alarm_flag_o, uip_o, irq_o}, 32'd0);

    // vector table: one second per entry
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      @(negedge clk);
      bin_mode = v[74]; hour24_mode = v[73];
      wr(3'd2, v[72:65]); wr(3'd1, v[64:57]); wr(3'd0, v[56:49]);   // R11
      wr(3'd5, v[48:41]); wr(3'd4, v[40:33]); wr(3'd3, v[32:25]);
      clr();
      ticks(TPS);
      chk($sformatf("R1 R2 R3 time vec%0d", k), {8'd0, hour_o, min_o, sec_o},
          {8'd0, v[24:17], v[16:9], v[8:1]});
      chk($sformatf("R4 R5 alarm vec%0d", k), {31'd0, alarm_flag_o}, {31'd0, v[0]});
      chk($sformatf("R5 update vec%0d", k), {31'd0, update_flag_o}, 32'd1);
    end

    // R6 hold mode
    bin_mode = 1'b0; hour24_mode = 1'b1;
    wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h10);
    wr(3'd3, 8'hC0); wr(3'd4, 8'hC0); wr(3'd5, 8'hC0);
    chk("R11 alarm write keeps time", {24'd0, sec_o}, 32'h10);
    @(negedge clk); set_hold = 1'b1; upd_irq_en = 1'b1;
    clr();
    ticks(TPS);
    chk("R6 time frozen", {24'd0, sec_o}, 32'h10);
    chk("R6 update flag", {31'd0, update_flag_o}, 32'd1);
    chk("R6 no alarm", {31'd0, alarm_flag_o}, 32'd0);
    chk("R9 irq masked by hold", {31'd0, irq_o}, 32'd0);
    @(negedge clk); set_hold = 1'b0;
    #1 chk("R9 irq after hold release", {31'd0, irq_o}, 32'd1);

    // R9 alarm interrupt path
    clr();
    @(negedge clk); upd_irq_en = 1'b0; alm_irq_en = 1'b1;
    ticks(TPS);
    chk("R4 wildcard alarm", {31'd0, alarm_flag_o}, 32'd1);
    chk("R9 alarm irq", {31'd0, irq_o}, 32'd1);
    chk("R1 time 11", {24'd0, sec_o}, 32'h11);

    // R7 update-in-progress window
    clr();
    chk("R5 clear flags", {30'd0, update_flag_o, alarm_flag_o}, 32'd0);
    chk("R9 irq after clear", {31'd0, irq_o}, 32'd0);
    ticks(TPS - UIPT - 1);
    chk("R7 uip before window", {31'd0, uip_o}, 32'd0);
    ticks(1);
    chk("R7 uip in window", {31'd0, uip_o}, 32'd1);
    ticks(UIPT);
    chk("R7 uip after update", {31'd0, uip_o}, 32'd0);
    chk("R7 update done", {24'd0, sec_o}, 32'h12);

    // R8 divider reset
    clr();
    @(negedge clk) div_reset = 1'b1;
    ticks(100);
    chk("R8 parked time", {24'd0, sec_o}, 32'h12);
    chk("R8 parked flag", {31'd0, update_flag_o}, 32'd0);
    chk("R8 parked uip", {31'd0, uip_o}, 32'd0);
    @(negedge clk) div_reset = 1'b0;
    ticks(TPS / 2 - 1);
    chk("R8 no early update", {24'd0, sec_o}, 32'h12);
    chk("R8 no early flag", {31'd0, update_flag_o}, 32'd0);
    ticks(1);
    chk("R8 half-second update", {24'd0, sec_o}, 32'h13);
    chk("R8 flag after release", {31'd0, update_flag_o}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule